// File: doc/BRIEF.md
# Grouped Level-Interrupt Combiner

This block gathers a wide vector of level-sensitive interrupt sources and folds them into a small set of request lines for a parent interrupt controller. The sources are split into groups of eight. Four groups share one 32-bit bank, and each group sits in its own byte lane of that bank. Every group drives one output line, which is high while any source in its lane is both enabled and active.

Software controls the enables through two write-only views, one that sets enable bits and one that clears them. Bits written as zero are left alone, so several agents can each change their own sources without a read-modify-write. A status view returns the synchronised inputs after masking. Raw inputs pass through a two-flop synchroniser before they are masked, so the outputs follow the sources two clocks late.

The register port is a plain address, write data, write strobe and combinational read data port. The upper address bits select the bank and the low four bits select the register inside it.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is zero, every group output is low, and the status word of every bank reads zero.
- R2: A write to bank offset 0x0 sets the enable of each bit position where the write data is one. Enables at zero positions keep their value.
- R3: A write to bank offset 0x4 clears the enable of each bit position where the write data is one. Enables at zero positions keep their value.
- R4: A read at offset 0x0 or at offset 0x4 returns the bank's current 32-bit enable word.
- R5: A read at offset 0xC returns the synchronised source word ANDed with the enable word, so masked sources read as zero.
- R6: Group output `bank*4 + n` is the OR of status bits [8*n+7 : 8*n] of that bank.
- R7: Sources are levels. An output stays high for as long as an enabled source in its group stays high, and it falls two clocks after the last such source falls.
- R8: A change on a source reaches the status word and the group output after exactly two rising clock edges. After one edge no effect is visible.
- R9: Reads at any other offset (for example 0x8) return zero. Writes at any other offset leave all enables unchanged.
- R10: Writing 0xFF into one byte lane of the clear register disables that whole group and leaves the other three groups of the bank as they were.
- R11: Banks are independent. A write addressed to one bank changes no enable bit of another bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | BANK_W+4 | Register address: bank index above bit 3, offset in bits [3:0] |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_level | input | NUM_BANKS*32 | Raw level interrupt sources |
| grp_irq | output | NUM_BANKS*4 | One combined request per group |

## Verification
A register write takes effect at the rising edge where the strobe is sampled. The read data and the group outputs therefore show the new enables one edge after the write, and the bench samples them on the following falling edge. A source change needs two rising edges to pass the synchroniser. The bench drives sources on a falling edge and looks at the outputs one edge later, when they must not have changed yet, and again two edges later, when they must follow. Reads are combinational and are sampled just after the address settles away from any clock edge.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int WORD_W = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = WORD_W / LANE_W;

  localparam logic [3:0] OFF_SET    = 4'h0;
  localparam logic [3:0] OFF_CLR    = 4'h4;
  localparam logic [3:0] OFF_STATUS = 4'hC;

  // Next enable word after an optional set and an optional clear.
  function automatic logic [WORD_W-1:0] next_enable(
    input logic [WORD_W-1:0] cur,
    input logic [WORD_W-1:0] data,
    input logic              do_set,
    input logic              do_clr
  );
    logic [WORD_W-1:0] r;
    r = cur;
    if (do_set) r = r | data;
    if (do_clr) r = r & ~data;
    return r;
  endfunction

  // OR reduction of one byte lane.
  function automatic logic lane_any(
    input logic [WORD_W-1:0] word,
    input int                lane
  );
    return |word[lane*LANE_W +: LANE_W];
  endfunction
endpackage

// File: rtl/irq_comb_sync.sv
module irq_comb_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/irq_comb_bank.sv
module irq_comb_bank
  import irq_comb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [3:0]        off,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] raw,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] en_q,
  output logic [LANES-1:0]  irq
);
  logic [WORD_W-1:0] synced;
  logic [WORD_W-1:0] status;
  logic              set_hit;
  logic              clr_hit;

  irq_comb_sync #(.W(WORD_W)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (synced)
  );

  assign set_hit = we && (off == OFF_SET);
  assign clr_hit = we && (off == OFF_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= next_enable(en_q, wdata, set_hit, clr_hit);
  end

  assign status = synced & en_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign irq[g] = lane_any(status, g);
  end

  always_comb begin
    unique case (off)
      OFF_SET, OFF_CLR: rdata = en_q;
      OFF_STATUS:       rdata = status;
      default:          rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irq_comb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [WORD_W-1:0]           reg_wdata,
  input  logic                        reg_we,
  output logic [WORD_W-1:0]           reg_rdata,
  input  logic [NUM_BANKS*WORD_W-1:0] src_level,
  output logic [NUM_BANKS*LANES-1:0]  grp_irq
);
  logic [BANK_W-1:0]           bank_sel;
  logic [3:0]                  off;
  logic [NUM_BANKS*WORD_W-1:0] en_all;   // brought out for the checker
  logic [NUM_BANKS*WORD_W-1:0] rd_all;
  logic [NUM_BANKS-1:0]        bank_hit;

  assign bank_sel = reg_addr[ADDR_W-1:4];
  assign off      = reg_addr[3:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = (bank_sel == BANK_W'(b));

    irq_comb_bank bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && bank_hit[b]),
      .off   (off),
      .wdata (reg_wdata),
      .raw   (src_level[b*WORD_W +: WORD_W]),
      .rdata (rd_all[b*WORD_W +: WORD_W]),
      .en_q  (en_all[b*WORD_W +: WORD_W]),
      .irq   (grp_irq[b*LANES +: LANES])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_hit[b]) reg_rdata = rd_all[b*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/irq_group_combiner_chk.sv
module irq_group_combiner_chk
  import irq_comb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [WORD_W-1:0]           reg_wdata,
  input logic                        reg_we,
  input logic [NUM_BANKS*WORD_W-1:0] src_level,
  input logic [NUM_BANKS*LANES-1:0]  grp_irq,
  input logic [NUM_BANKS*WORD_W-1:0] en_all
);
  logic off_mapped;
  assign off_mapped = (reg_addr[3:0] == OFF_SET) || (reg_addr[3:0] == OFF_CLR);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (grp_irq == '0));

  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we || !off_mapped) |=> $stable(en_all));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(b*16 + 0)) |=>
        ((en_all[b*WORD_W +: WORD_W] & $past(reg_wdata)) == $past(reg_wdata)));

    assert_clear_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(b*16 + 4)) |=>
        ((en_all[b*WORD_W +: WORD_W] & $past(reg_wdata)) == '0));

    assert_other_bank_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr[ADDR_W-1:4] != (ADDR_W-4)'(b)) |=> $stable(en_all[b*WORD_W +: WORD_W]));
  end

  for (genvar g = 0; g < NUM_BANKS*LANES; g++) begin : g_g
    assert_masked_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_all[g*LANE_W +: LANE_W] == '0) |-> !grp_irq[g]);

    assert_two_cycle_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] |-> ($past(src_level[g*LANE_W +: LANE_W], 2) != '0));
  end
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_we    (reg_we),
  .src_level (src_level),
  .grp_irq   (grp_irq),
  .en_all    (en_all)
);

// File: tb/irq_group_combiner_tb_top.sv
module irq_group_combiner_tb_top;
  localparam int NB = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [63:0] src_level = '0;
  logic [7:0]  grp_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_group_combiner #(.NUM_BANKS(NB)) dut_i (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
    .reg_we (reg_we), .reg_rdata (reg_rdata), .src_level (src_level), .grp_irq (grp_irq)
  );

  // set mask, clear mask, bank-0 source word, expected enable, expected status, expected irq
  localparam int NV = 6;
  localparam logic [32*5+4-1:0] VEC [NV] = '{
    {32'h0000_00FF, 32'h0000_0000, 32'h0000_0001, 32'h0000_00FF, 32'h0000_0001, 4'b0001},
    {32'h0000_FF00, 32'h0000_0000, 32'h0000_0100, 32'h0000_FFFF, 32'h0000_0100, 4'b0010},
    {32'h0000_0000, 32'h0000_00FF, 32'h0000_0101, 32'h0000_FF00, 32'h0000_0100, 4'b0010},
    {32'hA500_0000, 32'h0000_0000, 32'hFF00_0000, 32'hA500_FF00, 32'hA500_0000, 4'b1000},
    {32'h0033_0000, 32'h0000_F000, 32'h0011_0F00, 32'hA533_0F00, 32'h0011_0F00, 4'b0110},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h00, r); check("R1 enable bank0", r, 32'h0);
    rd(5'h1C, r); check("R1 status bank1", r, 32'h0);
    check("R1 irq", {24'h0, grp_irq}, 32'h0);

    // vector table on bank 0 (R2 R3 R4 R5 R6)
    for (int i = 0; i < NV; i++) begin
      logic [31:0] sm, cm, sv, ee, es;
      logic [3:0]  ei;
      {sm, cm, sv, ee, es, ei} = VEC[i];
      if (sm != 0) wr(5'h00, sm);
      if (cm != 0) wr(5'h04, cm);
      @(negedge clk);
      src_level[31:0] = sv;
      @(negedge clk); @(negedge clk);
      rd(5'h00, r); check("R2 R4 enable via set view", r, ee);
      rd(5'h04, r); check("R3 R4 enable via clear view", r, ee);
      rd(5'h0C, r); check("R5 status", r, es);
      check("R5 status vs src&en", r, sv & ee);
      check("R6 group outputs", {28'h0, grp_irq[3:0]}, {28'h0, ei});
    end

    // R8 latency and R7 level hold
    src_level = '0;
    wr(5'h00, 32'h0000_0001);
    @(negedge clk); @(negedge clk);
    src_level[0] = 1'b1;
    @(negedge clk);
    check("R8 no effect after one edge", {31'h0, grp_irq[0]}, 32'h0);
    @(negedge clk);
    check("R8 visible after two edges", {31'h0, grp_irq[0]}, 32'h1);
    repeat (5) @(negedge clk);
    check("R7 level held", {31'h0, grp_irq[0]}, 32'h1);
    src_level[0] = 1'b0;
    @(negedge clk);
    check("R7 still high one edge after drop", {31'h0, grp_irq[0]}, 32'h1);
    @(negedge clk);
    check("R7 low two edges after drop", {31'h0, grp_irq[0]}, 32'h0);

    // R9 unmapped offsets
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h00, r); check("R9 unmapped write ignored", r, 32'h0000_0001);
    rd(5'h08, r); check("R9 unmapped read zero", r, 32'h0);

    // R10 whole-lane clear
    wr(5'h00, 32'hFFFF_FFFF);
    src_level[31:0] = 32'hFFFF_FFFF;
    wr(5'h04, 32'h00FF_0000);
    @(negedge clk); @(negedge clk);
    rd(5'h00, r); check("R10 lane cleared", r, 32'hFF00_FFFF);
    check("R10 outputs", {28'h0, grp_irq[3:0]}, 32'h0000_000B);

    // R11 bank independence
    wr(5'h10, 32'h0000_0F00);
    src_level[63:32] = 32'h0000_0100;
    @(negedge clk); @(negedge clk);
    rd(5'h00, r); check("R11 bank0 untouched", r, 32'hFF00_FFFF);
    rd(5'h10, r); check("R11 bank1 enable", r, 32'h0000_0F00);
    check("R11 bank1 outputs", {28'h0, grp_irq[7:4]}, 32'h0000_0002);

    finish_run();
  end
endmodule